// File: doc/BRIEF.md
# Pipelined SRAM Bank Select with Echo-Clock Gating

This block is the synchronous front end of a pipelined SRAM bank. On each rising clock edge it samples an address, an active-low write strobe, a data-out enable and three chip enables. One enable is always active low. The other two have an active level that a static strap input sets for each of them. The bank is selected only when all three enables are at their active levels. A selected cycle with the write strobe low stores data into a small parameterised synchronous array. A selected cycle with the write strobe high starts a read.

The read result, its valid flag and the echo-clock gate all travel through the same pipeline, so they reach the outputs in the same cycle. Two true-phase and two inverted-phase echo-clock outputs toggle on every cycle alongside the data. They stop only when the bank was deselected through one of the strap-programmed enables. A deselect through the fixed enable blanks the data but leaves the echo clocks running.

The strap programming lets four copies form one deeper memory with no glue logic. Strap the copies 00, 01, 10 and 11, and drive their programmable enables from two high address bits.

Top module: `sram_bank_front`

## Requirements
- R1: Programmable enable A counts as active when `en_a` equals `pol_a`, and enable B when `en_b` equals `pol_b`. A strap value of 1 makes the enable active high; a strap value of 0 makes it active low.
- R2: The bank is selected only when `en_fix_n` is 0 and both programmable enables are active. A write (`wr_n`=0) changes the array only in a selected cycle, so an unselected write leaves the stored word unchanged.
- R3: A selected read with `dout_en`=1, sampled at edge k, puts the stored word on `dout` with `dout_vld`=1 in the cycle after edge k+RD_LAT-1 (RD_LAT defaults to 2).
- R4: For a cycle that was not a selected read with `dout_en`=1, `dout_vld` is 0 and `dout` is all zeros in the matching output cycle.
- R5: A cycle sampled with either programmable enable inactive drives all four echo outputs (`cq_t[1:0]`, `cq_c[1:0]`) to 0 in the matching output cycle, RD_LAT-1 edges later, exactly like the data.
- R6: A cycle sampled with `en_fix_n`=1 and both programmable enables active leaves the echo outputs running.
- R7: While running, `cq_t[0]`=`cq_t[1]`, each `cq_c` bit is the inverse of `cq_t`, and `cq_t` changes value on every cycle.
- R8: Consider four instances strapped {pol_b,pol_a}=00, 01, 10 and 11, with {en_b,en_a} taken from the same two address bits. For any value of those bits, exactly one instance returns valid read data.
- R9: Synchronous active-high reset `rst` clears every pipeline stage to the deselected state: `dout_vld`=0, `dout`=0 and all echo outputs at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| wr_n | input | 1 | Write strobe, active low |
| din | input | DATA_W | Write data |
| dout_en | input | 1 | Data-output enable for the read sampled this cycle |
| en_fix_n | input | 1 | Fixed active-low chip enable |
| en_a | input | 1 | Programmable chip enable A |
| en_b | input | 1 | Programmable chip enable B |
| pol_a | input | 1 | Strap: active level of enable A |
| pol_b | input | 1 | Strap: active level of enable B |
| dout | output | DATA_W | Read data, zero when not valid |
| dout_vld | output | 1 | Read data valid |
| cq_t | output | 2 | True-phase echo clocks |
| cq_c | output | 2 | Inverted-phase echo clocks |

## Verification
A stuck or misaligned control stage appears at the ports as `dout_vld` or the echo outputs changing one cycle early or late compared with the data. The bench pins this down by checking the echo outputs in the intermediate cycle before a deselect reaches the outputs, and again in the cycle when it arrives. A wrong polarity decode or a write gate that leaks appears within RD_LAT cycles as a valid flag on the wrong strap setting, or as a changed word when a location is read back. A broken phase register appears within two cycles as echo outputs that fail to toggle or fail to stay complementary.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  // An enable is active when it matches its strap level.
  function automatic logic en_match(input logic en, input logic strap);
    return ~(en ^ strap);
  endfunction

  typedef struct packed {
    logic vld;   // selected read with output enabled
    logic echo;  // programmable enables both active
  } sbf_ctl_t;
endpackage

// File: rtl/sbf_decode.sv
module sbf_decode
  import sbf_pkg::*;
(
  input  logic en_fix_n,
  input  logic en_a,
  input  logic en_b,
  input  logic pol_a,
  input  logic pol_b,
  input  logic wr_n,
  output logic prog_ok,
  output logic sel,
  output logic we,
  output logic re
);
  always_comb begin
    prog_ok = en_match(en_a, pol_a) & en_match(en_b, pol_b);
    sel     = prog_ok & ~en_fix_n;
    we      = sel & ~wr_n;
    re      = sel & wr_n;
  end
endmodule

// File: rtl/sbf_mem.sv
module sbf_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[addr] <= wdata;
    if (re) rdata     <= ram[addr];
  end
endmodule

// File: rtl/sbf_pipe.sv
module sbf_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_thru
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sbf_echo.sv
module sbf_echo (
  input  logic       clk,
  input  logic       rst,
  input  logic       echo_on,
  output logic [1:0] cq_t,
  output logic [1:0] cq_c
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  assign cq_t = {2{echo_on &  phase}};
  assign cq_c = {2{echo_on & ~phase}};

  // R7: a running echo clock flips every cycle
  assert_echo_toggles_R7: assert property (@(posedge clk) disable iff (rst)
    (echo_on && $past(echo_on) && !$past(rst)) |-> (cq_t != $past(cq_t)));

  // R7: true and inverted outputs stay complementary while running
  assert_echo_complement_R7: assert property (@(posedge clk) disable iff (rst)
    echo_on |-> ((cq_t ^ cq_c) == 2'b11));
endmodule

// File: rtl/sram_bank_front.sv
module sram_bank_front
  import sbf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int RD_LAT = 2   // must be at least 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] din,
  input  logic              dout_en,
  input  logic              en_fix_n,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              pol_a,
  input  logic              pol_b,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld,
  output logic [1:0]        cq_t,
  output logic [1:0]        cq_c
);
  localparam int TAIL   = RD_LAT - 1;
  localparam int CTL_W  = $bits(sbf_ctl_t);
  localparam int PIPE_W = DATA_W + CTL_W;

  logic prog_ok, sel, we, re;

  sbf_decode u_dec (
    .en_fix_n (en_fix_n),
    .en_a     (en_a),
    .en_b     (en_b),
    .pol_a    (pol_a),
    .pol_b    (pol_b),
    .wr_n     (wr_n),
    .prog_ok  (prog_ok),
    .sel      (sel),
    .we       (we),
    .re       (re)
  );

  // First stage: array read and control captured together.
  logic [DATA_W-1:0] rd_q;
  sbf_ctl_t          ctl_q;

  sbf_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (we),
    .re    (re),
    .addr  (addr),
    .wdata (din),
    .rdata (rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else begin
      ctl_q.vld  <= re & dout_en;
      ctl_q.echo <= prog_ok;
    end
  end

  // Remaining stages carry data and control in lockstep.
  logic [PIPE_W-1:0] pipe_q;
  sbf_ctl_t          ctl_o;
  logic [DATA_W-1:0] data_o;

  sbf_pipe #(.W(PIPE_W), .DEPTH(TAIL)) u_pipe (
    .clk (clk),
    .rst (rst),
    .d   ({ctl_q, rd_q}),
    .q   (pipe_q)
  );

  assign ctl_o    = sbf_ctl_t'(pipe_q[PIPE_W-1 -: CTL_W]);
  assign data_o   = pipe_q[DATA_W-1:0];
  assign dout_vld = ctl_o.vld;
  assign dout     = ctl_o.vld ? data_o : '0;

  sbf_echo u_echo (
    .clk     (clk),
    .rst     (rst),
    .echo_on (ctl_o.echo),
    .cq_t    (cq_t),
    .cq_c    (cq_c)
  );

  // R2: the array is written only with the fixed enable asserted
  assert_write_needs_fix_R2: assert property (@(posedge clk) disable iff (rst)
    we |-> !en_fix_n);

  // R5: valid data never leaves while the echo clocks are gated off
  assert_vld_with_echo_R5: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> ((cq_t ^ cq_c) == 2'b11));

  // R4: invalid output cycles carry all-zero data
  assert_blank_data_R4: assert property (@(posedge clk) disable iff (rst)
    !dout_vld |-> (dout == '0));
endmodule

// File: tb/sram_bank_front_tb.sv
module sram_bank_front_tb;
  localparam int AW  = 8;
  localparam int DW  = 16;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          wr_n, dout_en, en_fix_n, en_a, en_b, pol_a, pol_b;
  logic [DW-1:0] din, dout;
  logic          dout_vld;
  logic [1:0]    cq_t, cq_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  sram_bank_front #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_n(wr_n), .din(din),
    .dout_en(dout_en), .en_fix_n(en_fix_n), .en_a(en_a), .en_b(en_b),
    .pol_a(pol_a), .pol_b(pol_b), .dout(dout), .dout_vld(dout_vld),
    .cq_t(cq_t), .cq_c(cq_c)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a, ~a} ^ 16'h5A3C;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Idle: fixed enable off, programmable enables active -> echo running.
  task automatic idle();
    wr_n = 1'b1; dout_en = 1'b1; en_fix_n = 1'b1;
    en_a = pol_a; en_b = pol_b; din = '0;
  endtask

  task automatic issue(input logic w_n, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic fn, input logic ea, input logic eb, input logic oe);
    addr = a; wr_n = w_n; din = d; en_fix_n = fn; en_a = ea; en_b = eb; dout_en = oe;
    tick();
    idle();
  endtask

  task automatic echo_running(input string req);
    chk(req, {30'd0, cq_t ^ cq_c}, 32'd3);
  endtask

  task automatic t_reset();
    rst = 1'b1; pol_a = 1'b1; pol_b = 1'b0; addr = '0; idle();
    tick(); tick();
    chk("R9 vld", {31'd0, dout_vld}, 0);
    chk("R9 dout", {16'd0, dout}, 0);
    chk("R9 echo", {28'd0, cq_t, cq_c}, 0);
    rst = 1'b0;
  endtask

  task automatic t_write_read();
    for (int i = 0; i < 6; i++) issue(1'b0, AW'(i * 37), pat(AW'(i * 37)), 1'b0, pol_a, pol_b, 1'b1);
    for (int i = 0; i < 6; i++) begin
      issue(1'b1, AW'(i * 37), '0, 1'b0, pol_a, pol_b, 1'b1);
      repeat (LAT - 1) tick();
      chk("R3 vld", {31'd0, dout_vld}, 1);
      chk("R3 data", {16'd0, dout}, {16'd0, pat(AW'(i * 37))});
    end
  endtask

  task automatic t_polarity();
    // R1: flip straps; enable levels follow the strap value
    pol_a = 1'b0; pol_b = 1'b1; idle();
    issue(1'b1, AW'(37), '0, 1'b0, 1'b0, 1'b1, 1'b1);
    repeat (LAT - 1) tick();
    chk("R1 low-active A sel", {31'd0, dout_vld}, 1);
    issue(1'b1, AW'(37), '0, 1'b0, 1'b1, 1'b1, 1'b1);
    repeat (LAT - 1) tick();
    chk("R1 A inactive", {31'd0, dout_vld}, 0);
    pol_a = 1'b1; pol_b = 1'b0; idle();
  endtask

  task automatic t_unselected_write();
    issue(1'b0, AW'(74), 16'hDEAD, 1'b1, pol_a, pol_b, 1'b1);
    issue(1'b0, AW'(74), 16'hBEEF, 1'b0, ~pol_a, pol_b, 1'b1);
    issue(1'b1, AW'(74), '0, 1'b0, pol_a, pol_b, 1'b1);
    repeat (LAT - 1) tick();
    chk("R2 word kept", {16'd0, dout}, {16'd0, pat(AW'(74))});
  endtask

  task automatic t_blank();
    issue(1'b1, AW'(0), '0, 1'b0, pol_a, pol_b, 1'b0);
    repeat (LAT - 1) tick();
    chk("R4 oe off vld", {31'd0, dout_vld}, 0);
    chk("R4 oe off data", {16'd0, dout}, 0);
    issue(1'b1, AW'(0), '0, 1'b1, pol_a, pol_b, 1'b1);
    repeat (LAT - 1) tick();
    chk("R4 fix off vld", {31'd0, dout_vld}, 0);
    echo_running("R6 fix deselect keeps echo");
  endtask

  task automatic t_echo_gate();
    issue(1'b1, AW'(0), '0, 1'b0, pol_a, ~pol_b, 1'b1);
    if (LAT > 1) begin
      echo_running("R5 not yet gated");
      repeat (LAT - 1) tick();
    end
    chk("R5 echo off", {28'd0, cq_t, cq_c}, 0);
    chk("R5 vld off", {31'd0, dout_vld}, 0);
    tick();
    echo_running("R5 echo back");
  endtask

  task automatic t_echo_toggle();
    logic [1:0] prev;
    prev = cq_t;
    for (int i = 0; i < 4; i++) begin
      tick();
      echo_running("R7 complement");
      chk("R7 pair equal", {31'd0, cq_t[0] ^ cq_t[1]}, 0);
      chk("R7 toggle", {30'd0, cq_t}, {30'd0, ~prev});
      prev = cq_t;
    end
  endtask

  task automatic t_four_bank();
    for (int s = 0; s < 4; s++) begin
      int hits = 0;
      pol_a = s[0]; pol_b = s[1]; idle();
      issue(1'b0, AW'(111), pat(AW'(111)), 1'b0, pol_a, pol_b, 1'b1);
      for (int c = 0; c < 4; c++) begin
        issue(1'b1, AW'(111), '0, 1'b0, c[0], c[1], 1'b1);
        repeat (LAT - 1) tick();
        chk("R8 bank select", {31'd0, dout_vld}, {31'd0, (s == c)});
        if (dout_vld) hits++;
      end
      chk("R8 one hit", hits, 1);
    end
    pol_a = 1'b1; pol_b = 1'b0; idle();
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_polarity();
    t_unselected_write();
    t_blank();
    t_echo_gate();
    t_echo_toggle();
    t_four_bank();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule